// File: doc/BRIEF.md
# Bayer Tile to 4:2:0 Macroblock Converter

This block takes one square tile of raw colour-mosaic pixels, 20 by 20, and turns it into a single 4:2:0 macroblock. The macroblock has four 8x8 luma blocks, then one 8x8 blue-difference block and one 8x8 red-difference block. Neighbouring tiles overlap. The two-pixel ring around the central 16x16 area is never emitted. It only supplies the neighbours that colour interpolation needs, so each tile is self-contained and no line storage is shared between tiles. Tiles arrive one at a time, in macroblock order, from a frame-buffer read stream.

A one-cycle tile-start strobe opens a tile. The block then takes the 400 pixels in row-major order over a valid/ready handshake and holds them in a private tile store. It then streams out 384 samples over a second valid/ready handshake. Each sample carries the index of its block, and the final sample carries a last flag. Input acceptance and output emission never overlap. A new tile can begin only once the final sample of the previous one has been taken.

Top module: `bayer_mb_conv`

## Requirements
- R1: After reset, `smp_valid` and `pix_ready` are both low.
- R2: A `tile_start` pulse while idle raises `pix_ready` on the next cycle. Exactly 400 pixels are then accepted in row-major order (tile row 0 columns 0..19 first). After the 400th transfer, `pix_ready` is low and `smp_valid` is low whenever `pix_ready` is high.
- R3: `tile_start` has no effect while a tile is being loaded or emitted. This includes the cycle in which the final sample is accepted. No new load begins until a later pulse arrives while idle.
- R4: Each tile yields 384 samples as six blocks of 64, each block in row-major order. `smp_blk` is 0..3 for luma, 4 for blue difference and 5 for red difference. Luma block 0 covers tile rows/columns 2..9/2..9, block 1 rows 2..9 and columns 10..17, block 2 rows 10..17 and columns 2..9, and block 3 rows 10..17 and columns 10..17.
- R5: The mosaic has red at even row and even column, blue at odd row and odd column, and green elsewhere (tile coordinates). A missing colour is the truncated mean of its nearest same-colour neighbours: the four orthogonal or four diagonal pixels (sum >> 2), or the two horizontal or two vertical pixels (sum >> 1).
- R6: Luma is (77R + 150G + 29B + 128) >> 8, limited to 0..255.
- R7: Per pixel, Cb = floor((-43R - 85G + 128B + 128) / 256) + 128 and Cr = floor((128R - 107G - 21B + 128) / 256) + 128, each limited to 0..255.
- R8: Chroma sample (r, c) is (sum of the four per-pixel values at tile rows 2+2r, 3+2r and columns 2+2c, 3+2c, plus 2) >> 2.
- R9: While `smp_valid` is high and `smp_ready` is low, `smp_valid`, `smp_data`, `smp_blk` and `smp_last` hold their values.
- R10: `smp_last` is high only on the final sample of block 5. After that sample is accepted, `smp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tile_start | input | 1 | One-cycle strobe that opens a tile while idle |
| pix_valid | input | 1 | Raw pixel on `pix_data` is valid |
| pix_ready | output | 1 | Block accepts a raw pixel this cycle |
| pix_data | input | 8 | Raw mosaic pixel |
| smp_valid | output | 1 | Output sample is valid |
| smp_ready | input | 1 | Downstream takes the sample this cycle |
| smp_data | output | 8 | Luma or chroma sample |
| smp_blk | output | 3 | Block index of the sample (0..3 luma, 4 Cb, 5 Cr) |
| smp_last | output | 1 | Final sample of the macroblock |

## Verification
Two events can land in the same cycle: the downstream accepting the final red-difference sample, and a new `tile_start` strobe. The bench raises the strobe in exactly that cycle. It then checks that `smp_valid` drops, that `pix_ready` stays low, and that only a later strobe opens the next tile. A second collision is randomised backpressure arriving while the next sample is being formed. Whenever the output was stalled, the bench compares the held sample with its value from the cycle before. Every accepted sample is compared against a bench model of interpolation, colour conversion and chroma averaging.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
    localparam int PIX_W = 8;
    typedef logic [PIX_W-1:0] pix_t;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_EMIT  = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;
endpackage

// File: rtl/bmc_tile_buf.sv
// Holds one raw tile; single write port, 4x4 combinational read window.
module bmc_tile_buf
    import bmc_pkg::*;
#(
    parameter int TILE = 20
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [$clog2(TILE)-1:0]    wr_row,
    input  logic [$clog2(TILE)-1:0]    wr_col,
    input  pix_t                       wdata,
    input  logic [$clog2(TILE)-1:0]    org_row,
    input  logic [$clog2(TILE)-1:0]    org_col,
    output pix_t [3:0][3:0]            win
);
    localparam int AW = $clog2(TILE * TILE);

    pix_t mem [TILE*TILE];

    function automatic logic [AW-1:0] lin(input int r, input int c);
        return AW'(r * TILE + c);
    endfunction

    always_ff @(posedge clk) begin
        if (we) begin
            mem[lin(int'(wr_row), int'(wr_col))] <= wdata;
        end
    end

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                win[i][j] = mem[lin(int'(org_row) + i, int'(org_col) + j)];
            end
        end
    end
endmodule

// File: rtl/bmc_interp.sv
// Bilinear fill of the two missing colours at the centre of a 3x3 window.
module bmc_interp
    import bmc_pkg::*;
(
    input  pix_t [2:0][2:0] w,
    input  logic            row_odd,
    input  logic            col_odd,
    output pix_t            r,
    output pix_t            g,
    output pix_t            b
);
    localparam int SW4 = PIX_W + 2;
    localparam int SW2 = PIX_W + 1;

    logic [SW4-1:0] cross_s, diag_s;
    logic [SW2-1:0] horiz_s, vert_s;
    pix_t           ctr, cross_a, diag_a, horiz_a, vert_a;

    always_comb begin
        ctr     = w[1][1];
        cross_s = SW4'(w[0][1]) + SW4'(w[2][1]) + SW4'(w[1][0]) + SW4'(w[1][2]);
        diag_s  = SW4'(w[0][0]) + SW4'(w[0][2]) + SW4'(w[2][0]) + SW4'(w[2][2]);
        horiz_s = SW2'(w[1][0]) + SW2'(w[1][2]);
        vert_s  = SW2'(w[0][1]) + SW2'(w[2][1]);
        cross_a = cross_s[SW4-1:2];
        diag_a  = diag_s[SW4-1:2];
        horiz_a = horiz_s[SW2-1:1];
        vert_a  = vert_s[SW2-1:1];
        unique case ({row_odd, col_odd})
            2'b00: begin r = ctr;     g = cross_a; b = diag_a;  end
            2'b01: begin r = horiz_a; g = ctr;     b = vert_a;  end
            2'b10: begin r = vert_a;  g = ctr;     b = horiz_a; end
            2'b11: begin r = diag_a;  g = cross_a; b = ctr;     end
        endcase
    end
endmodule

// File: rtl/bmc_luma.sv
// Fixed-point luma from one RGB triple.
module bmc_luma
    import bmc_pkg::*;
(
    input  pix_t r,
    input  pix_t g,
    input  pix_t b,
    output pix_t y
);
    localparam int ACC_W = 19;
    typedef logic signed [ACC_W-1:0] acc_t;
    localparam acc_t KR  = 19'sd77;
    localparam acc_t KG  = 19'sd150;
    localparam acc_t KB  = 19'sd29;
    localparam acc_t RND = 19'sd128;

    acc_t rs, gs, bs, acc, shf;

    always_comb begin
        rs  = $signed({{(ACC_W-PIX_W){1'b0}}, r});
        gs  = $signed({{(ACC_W-PIX_W){1'b0}}, g});
        bs  = $signed({{(ACC_W-PIX_W){1'b0}}, b});
        acc = KR * rs + KG * gs + KB * bs + RND;
        shf = acc >>> 8;
        if (shf < 19'sd0)        y = '0;
        else if (shf > 19'sd255) y = '1;
        else                     y = shf[PIX_W-1:0];
    end
endmodule

// File: rtl/bmc_chroma.sv
// Fixed-point colour differences from one RGB triple, offset to mid-scale.
module bmc_chroma
    import bmc_pkg::*;
(
    input  pix_t r,
    input  pix_t g,
    input  pix_t b,
    output pix_t cb,
    output pix_t cr
);
    localparam int ACC_W = 19;
    typedef logic signed [ACC_W-1:0] acc_t;
    localparam acc_t BR  = -19'sd43;
    localparam acc_t BG  = -19'sd85;
    localparam acc_t BB  = 19'sd128;
    localparam acc_t RR  = 19'sd128;
    localparam acc_t RG  = -19'sd107;
    localparam acc_t RB  = -19'sd21;
    localparam acc_t RND = 19'sd128;
    localparam acc_t OFS = 19'sd128;

    acc_t rs, gs, bs, cb_v, cr_v;

    function automatic pix_t sat(input acc_t v);
        if (v < 19'sd0)        return '0;
        else if (v > 19'sd255) return '1;
        else                   return v[PIX_W-1:0];
    endfunction

    always_comb begin
        rs   = $signed({{(ACC_W-PIX_W){1'b0}}, r});
        gs   = $signed({{(ACC_W-PIX_W){1'b0}}, g});
        bs   = $signed({{(ACC_W-PIX_W){1'b0}}, b});
        cb_v = ((BR * rs + BG * gs + BB * bs + RND) >>> 8) + OFS;
        cr_v = ((RR * rs + RG * gs + RB * bs + RND) >>> 8) + OFS;
        cb   = sat(cb_v);
        cr   = sat(cr_v);
    end
endmodule

// File: rtl/bayer_mb_conv.sv
// Tile load, per-sample window selection, interpolation lanes and output register.
module bayer_mb_conv
    import bmc_pkg::*;
#(
    parameter int TILE   = 20,
    parameter int BORDER = 2,
    parameter int BLK    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tile_start,
    input  logic       pix_valid,
    output logic       pix_ready,
    input  logic [7:0] pix_data,
    output logic       smp_valid,
    input  logic       smp_ready,
    output logic [7:0] smp_data,
    output logic [2:0] smp_blk,
    output logic       smp_last
);
    localparam int MB       = TILE - 2 * BORDER;
    localparam int LB_SIDE  = MB / BLK;
    localparam int NUM_LUMA = LB_SIDE * LB_SIDE;
    localparam int SUB      = 2;
    localparam int NLANE    = SUB * SUB;
    localparam int CW       = $clog2(TILE);
    localparam int BW       = $clog2(BLK);
    localparam int BIW      = 3;
    localparam int SUMW     = PIX_W + 2;
    localparam logic [BIW-1:0] BI_CB = BIW'(NUM_LUMA);
    localparam logic [BIW-1:0] BI_CR = BIW'(NUM_LUMA + 1);

    typedef struct packed {
        phase_e          ph;
        logic [CW-1:0]   wr_r;
        logic [CW-1:0]   wr_c;
        logic [BIW-1:0]  blk;
        logic [BW-1:0]   row;
        logic [BW-1:0]   col;
        logic            ov;
        pix_t            od;
        logic [BIW-1:0]  ob;
        logic            ol;
    } st_t;

    st_t st_d, st_q;

    logic            buf_we;
    logic [CW-1:0]   org_row, org_col;
    logic            par_row, par_col;
    pix_t [3:0][3:0] win;
    int              ctr_y, ctr_x;

    pix_t lane_r  [NLANE];
    pix_t lane_g  [NLANE];
    pix_t lane_b  [NLANE];
    pix_t lane_cb [NLANE];
    pix_t lane_cr [NLANE];
    pix_t luma_v, cb_avg, cr_avg, sample;
    logic [SUMW-1:0] cb_sum, cr_sum;
    logic            is_final;

    bmc_tile_buf #(.TILE(TILE)) u_buf (
        .clk     (clk),
        .we      (buf_we),
        .wr_row  (st_q.wr_r),
        .wr_col  (st_q.wr_c),
        .wdata   (pix_data),
        .org_row (org_row),
        .org_col (org_col),
        .win     (win)
    );

    // Centre of the first lane for the sample under the emit counters.
    always_comb begin
        if (st_q.blk < BI_CB) begin
            ctr_y = BORDER + (int'(st_q.blk) / LB_SIDE) * BLK + int'(st_q.row);
            ctr_x = BORDER + (int'(st_q.blk) % LB_SIDE) * BLK + int'(st_q.col);
        end else begin
            ctr_y = BORDER + SUB * int'(st_q.row);
            ctr_x = BORDER + SUB * int'(st_q.col);
        end
        org_row = CW'(ctr_y - 1);
        org_col = CW'(ctr_x - 1);
        par_row = ctr_y[0];
        par_col = ctr_x[0];
    end

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        localparam int DY = k / SUB;
        localparam int DX = k % SUB;
        pix_t [2:0][2:0] w;
        always_comb begin
            for (int i = 0; i < 3; i++) begin
                for (int j = 0; j < 3; j++) begin
                    w[i][j] = win[DY + i][DX + j];
                end
            end
        end
        bmc_interp u_interp (
            .w       (w),
            .row_odd (par_row ^ 1'(DY)),
            .col_odd (par_col ^ 1'(DX)),
            .r       (lane_r[k]),
            .g       (lane_g[k]),
            .b       (lane_b[k])
        );
        bmc_chroma u_chroma (
            .r  (lane_r[k]),
            .g  (lane_g[k]),
            .b  (lane_b[k]),
            .cb (lane_cb[k]),
            .cr (lane_cr[k])
        );
    end

    bmc_luma u_luma (
        .r (lane_r[0]),
        .g (lane_g[0]),
        .b (lane_b[0]),
        .y (luma_v)
    );

    always_comb begin
        cb_sum = SUMW'(SUB);
        cr_sum = SUMW'(SUB);
        for (int k = 0; k < NLANE; k++) begin
            cb_sum = cb_sum + SUMW'(lane_cb[k]);
            cr_sum = cr_sum + SUMW'(lane_cr[k]);
        end
        cb_avg = cb_sum[SUMW-1:2];
        cr_avg = cr_sum[SUMW-1:2];
        if (st_q.blk < BI_CB)       sample = luma_v;
        else if (st_q.blk == BI_CB) sample = cb_avg;
        else                        sample = cr_avg;
        is_final = (st_q.blk == BI_CR) && (st_q.row == BW'(BLK - 1))
                   && (st_q.col == BW'(BLK - 1));
    end

    always_comb begin
        st_d   = st_q;
        buf_we = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (tile_start) begin
                    st_d.ph   = PH_LOAD;
                    st_d.wr_r = '0;
                    st_d.wr_c = '0;
                end
            end
            PH_LOAD: begin
                if (pix_valid) begin
                    buf_we = 1'b1;
                    if (st_q.wr_c == CW'(TILE - 1)) begin
                        st_d.wr_c = '0;
                        if (st_q.wr_r == CW'(TILE - 1)) begin
                            st_d.ph  = PH_EMIT;
                            st_d.blk = '0;
                            st_d.row = '0;
                            st_d.col = '0;
                        end else begin
                            st_d.wr_r = st_q.wr_r + 1'b1;
                        end
                    end else begin
                        st_d.wr_c = st_q.wr_c + 1'b1;
                    end
                end
            end
            PH_EMIT: begin
                if (!st_q.ov || smp_ready) begin
                    st_d.ov = 1'b1;
                    st_d.od = sample;
                    st_d.ob = st_q.blk;
                    st_d.ol = is_final;
                    if (is_final) begin
                        st_d.ph = PH_DRAIN;
                    end else if (st_q.col == BW'(BLK - 1)) begin
                        st_d.col = '0;
                        if (st_q.row == BW'(BLK - 1)) begin
                            st_d.row = '0;
                            st_d.blk = st_q.blk + 1'b1;
                        end else begin
                            st_d.row = st_q.row + 1'b1;
                        end
                    end else begin
                        st_d.col = st_q.col + 1'b1;
                    end
                end
            end
            PH_DRAIN: begin
                if (st_q.ov && smp_ready) begin
                    st_d.ov = 1'b0;
                    st_d.ol = 1'b0;
                    st_d.ph = PH_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_ready = (st_q.ph == PH_LOAD);
    assign smp_valid = st_q.ov;
    assign smp_data  = st_q.od;
    assign smp_blk   = st_q.ob;
    assign smp_last  = st_q.ol;
endmodule

// File: rtl/bayer_mb_conv_chk.sv
module bayer_mb_conv_chk #(
    parameter int BIW     = 3,
    parameter int LAST_BI = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pix_ready,
    input logic           smp_valid,
    input logic           smp_ready,
    input logic [7:0]     smp_data,
    input logic [BIW-1:0] smp_blk,
    input logic           smp_last
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && !smp_ready |=> smp_valid && $stable(smp_data)
                                    && $stable(smp_blk) && $stable(smp_last));

    // R10
    last_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && smp_last |-> smp_blk == BIW'(LAST_BI));

    // R10
    last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && smp_ready && smp_last |=> !smp_valid);

    // R2
    load_emit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> !smp_valid);

    // R4
    blk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> smp_blk <= BIW'(LAST_BI));

    // R4
    blk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && smp_ready && !smp_last |=> smp_valid
            && (smp_blk == $past(smp_blk) || smp_blk == $past(smp_blk) + 1'b1));
endmodule

bind bayer_mb_conv bayer_mb_conv_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_ready (pix_ready),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_data  (smp_data),
    .smp_blk   (smp_blk),
    .smp_last  (smp_last)
);

// File: tb/bayer_mb_conv_test.sv
module bayer_mb_conv_test;
    localparam int CLK_PERIOD = 10;
    localparam int T = 20;
    localparam int NSMP = 384;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tile_start = 1'b0;
    logic       pix_valid = 1'b0;
    logic       pix_ready;
    logic [7:0] pix_data = '0;
    logic       smp_valid;
    logic       smp_ready = 1'b0;
    logic [7:0] smp_data;
    logic [2:0] smp_blk;
    logic       smp_last;

    int  tile [T][T];
    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bayer_mb_conv uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tile_start (tile_start),
        .pix_valid  (pix_valid),
        .pix_ready  (pix_ready),
        .pix_data   (pix_data),
        .smp_valid  (smp_valid),
        .smp_ready  (smp_ready),
        .smp_data   (smp_data),
        .smp_blk    (smp_blk),
        .smp_last   (smp_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lim(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    // Missing colours per the mosaic layout: red at (even, even), blue at (odd, odd).
    function automatic void colour_at(input int y, input int x,
                                      output int r, output int g, output int b);
        int four, diag, hz, vt;
        four = (tile[y-1][x] + tile[y+1][x] + tile[y][x-1] + tile[y][x+1]) >> 2;
        diag = (tile[y-1][x-1] + tile[y-1][x+1] + tile[y+1][x-1] + tile[y+1][x+1]) >> 2;
        hz   = (tile[y][x-1] + tile[y][x+1]) >> 1;
        vt   = (tile[y-1][x] + tile[y+1][x]) >> 1;
        if (y % 2 == 0 && x % 2 == 0)      begin r = tile[y][x]; g = four; b = diag; end
        else if (y % 2 == 1 && x % 2 == 1) begin b = tile[y][x]; g = four; r = diag; end
        else if (y % 2 == 0)               begin g = tile[y][x]; r = hz;   b = vt;   end
        else                               begin g = tile[y][x]; r = vt;   b = hz;   end
    endfunction

    function automatic int expect_smp(input int blk, input int row, input int col);
        int r, g, b, s;
        if (blk < 4) begin
            colour_at(2 + (blk / 2) * 8 + row, 2 + (blk % 2) * 8 + col, r, g, b);
            return lim((77 * r + 150 * g + 29 * b + 128) >>> 8);
        end
        s = 0;
        for (int dy = 0; dy < 2; dy++) begin
            for (int dx = 0; dx < 2; dx++) begin
                colour_at(2 + 2 * row + dy, 2 + 2 * col + dx, r, g, b);
                if (blk == 4) s += lim(((-43 * r - 85 * g + 128 * b + 128) >>> 8) + 128);
                else          s += lim(((128 * r - 107 * g - 21 * b + 128) >>> 8) + 128);
            end
        end
        return (s + 2) >> 2;
    endfunction

    function automatic void fill(input int mode);
        for (int y = 0; y < T; y++) begin
            for (int x = 0; x < T; x++) begin
                case (mode)
                    0: tile[y][x] = 0;
                    1: tile[y][x] = 255;
                    2: tile[y][x] = (y % 2 == 0 && x % 2 == 0) ? 255 : 0;
                    3: tile[y][x] = (y % 2 == 1 && x % 2 == 1) ? 255 : 0;
                    4: tile[y][x] = ((y + x) % 2 == 1) ? 255 : 0;
                    default: tile[y][x] = int'($urandom_range(0, 255));
                endcase
            end
        end
    endfunction

    task automatic run_tile(input int vprob, input int rprob, input bit poke);
        int   idx = 0;
        int   n = 0;
        bit   stalled = 1'b0;
        bit   r2_seen = 1'b0;
        bit   r3_seen = 1'b0;
        logic [7:0] hd;
        logic [2:0] hb;
        int   eb, er, ec;
        @(negedge clk);
        tile_start = 1'b1;
        @(negedge clk);
        tile_start = 1'b0;
        check(pix_ready === 1'b1, "R2 ready after strobe", int'(pix_ready), 1);
        while (n < NSMP) begin
            if (stalled) begin
                // R9: held sample unchanged after a stalled cycle
                check(smp_valid === 1'b1 && smp_data === hd && smp_blk === hb,
                      "R9 hold under backpressure", int'(smp_data), int'(hd));
            end
            stalled = 1'b0;
            if (idx == T * T && !r2_seen) begin
                r2_seen = 1'b1;
                check(pix_ready === 1'b0, "R2 closed after 400", int'(pix_ready), 0);
            end
            if (poke && n >= 110 && !r3_seen && idx == T * T) begin
                r3_seen = 1'b1;
                check(pix_ready === 1'b0, "R3 strobe during emit", int'(pix_ready), 0);
            end
            tile_start = poke && (n >= 100) && (n < 104);
            smp_ready = ($urandom_range(0, 99) < rprob);
            if (idx < T * T) begin
                pix_valid = ($urandom_range(0, 99) < vprob);
                pix_data  = 8'(tile[idx / T][idx % T]);
                if (pix_valid && pix_ready) idx++;
            end else begin
                pix_valid = 1'b0;
            end
            if (smp_valid && smp_ready) begin
                eb = n / 64; er = (n % 64) / 8; ec = n % 8;
                check(int'(smp_blk) == eb, "R4 block index", int'(smp_blk), eb);
                check(int'(smp_data) == expect_smp(eb, er, ec),
                      (eb < 4) ? "R5 R6 luma sample" : "R5 R7 R8 chroma sample",
                      int'(smp_data), expect_smp(eb, er, ec));
                check(smp_last === (n == NSMP - 1), "R10 last flag",
                      int'(smp_last), int'(n == NSMP - 1));
                n++;
                if (n == NSMP && poke) tile_start = 1'b1;
            end else if (smp_valid) begin
                stalled = 1'b1;
                hd = smp_data;
                hb = smp_blk;
            end
            @(negedge clk);
        end
        check(smp_valid === 1'b0, "R10 idle after last", int'(smp_valid), 0);
        check(pix_ready === 1'b0, "R3 strobe on final accept", int'(pix_ready), 0);
        tile_start = 1'b0;
        smp_ready  = 1'b0;
        @(negedge clk);
        check(pix_ready === 1'b0 && smp_valid === 1'b0, "R3 still idle",
              int'(pix_ready), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check(smp_valid === 1'b0, "R1 out valid in reset", int'(smp_valid), 0);
        check(pix_ready === 1'b0, "R1 in ready in reset", int'(pix_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(smp_valid === 1'b0 && pix_ready === 1'b0, "R1 after reset",
              int'(pix_ready), 0);
        fill(0); run_tile(100, 100, 1'b0);
        fill(1); run_tile(100, 100, 1'b1);
        fill(2); run_tile(70, 50, 1'b1);
        fill(3); run_tile(90, 30, 1'b0);
        fill(4); run_tile(60, 90, 1'b1);
        for (int t = 0; t < 14; t++) begin
            fill(9);
            run_tile(int'($urandom_range(30, 100)), int'($urandom_range(25, 100)), t[0]);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule